// File: doc/BRIEF.md
# Trap and Interrupt Control Unit

This block is the privileged control unit beside a small 32-bit RISC pipeline. It holds three architectural registers: a status word, a cause word and a saved return address. The pipeline reports a synchronous fault as a valid strobe, a 5-bit fault code and the address of the faulting instruction. Six hardware request lines and two software request bits feed an 8-bit pending field. Each cycle the unit decides whether to enter the trap handler, return from it, or do nothing. Entry and return are shown to the fetch stage as a one-cycle redirect pulse with a target address.

Every trap goes to one fixed handler entry. The handler tells the cases apart by reading the cause word. Its code field is zero for an interrupt and non-zero for a synchronous fault. Software reads and writes the three registers through a select-addressed port, and it leaves the handler with a return strobe.

Top module: `trap_unit`

## Requirements
- R1: After reset the status, cause and saved-address registers read 0, no redirect is driven and user mode is indicated.
- R2: A fault report (valid high at a clock edge) drives redirect high for the next cycle with target 0x80000180 and sets the exception-level flag (status bit 1), which drops user mode.
- R3: On entry from user mode the saved address takes the faulting address unchanged, with no +4 adjustment. An interrupt entry saves the value on the interrupted-address input.
- R4: Cause bits 6:2 take the fault code on fault entry and 0 on interrupt entry. Overflow (12) gives cause 0x30, undefined instruction (10) gives 0x28 and bad data address (4) gives 0x10.
- R5: Cause bits 15:8 are pending flags. A hardware request sets its flag at the clock edge whatever the mask. Line 0 (keyboard) maps to bit 8 and line k (k = 1..5) maps to bit 10+k.
- R6: An interrupt is taken at the edge after the point where status bit 0 (global enable) is 1, status bit 1 is 0, and some pending bit 15:8 has its mask bit set in status bits 15:8.
- R7: Cause bits 9 and 10 are software pending flags, set and cleared only by a cause write. A cause write of 0 clears a hardware flag whose line is low, and a write of 1 to a hardware flag has no effect.
- R8: When a fault report and a takeable interrupt coincide, the fault is taken: the fault code and faulting address are recorded, and the pending flag stays set.
- R9: While the exception level is set, no interrupt is taken. A fault in that state redirects and updates the code but keeps the saved address.
- R10: A return strobe with no fault report redirects to the saved address (the value before any same-cycle write) and clears the exception level.
- R11: Register select 0 is status, 1 is cause, 2 is the saved address and 3 reads 0. Cause bit 31 (delay-slot flag) and every unused bit read 0, and the cause code field is not writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid_i | input | 1 | Synchronous fault report strobe |
| exc_code_i | input | 5 | Fault code |
| exc_pc_i | input | 32 | Address of the faulting instruction |
| irq_pc_i | input | 32 | Address of the instruction an interrupt would preempt |
| hw_irq_i | input | 6 | Hardware interrupt request lines |
| eret_i | input | 1 | Return-from-handler strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register write select |
| wr_data_i | input | 32 | Register write data |
| rd_sel_i | input | 2 | Register read select |
| rd_data_o | output | 32 | Selected register value (combinational) |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc_o | output | 32 | Redirect target address |
| user_mode_o | output | 1 | High when the exception level is clear |

## Verification
A corrupted pending flag shows up in the cause read one cycle after the request. If it is also unmasked, it shows up as an unexpected or missing redirect pulse one cycle later. A wrong exception-level flag shows up right away on user_mode_o. It then shows up as an interrupt taken inside the handler, or blocked outside it. A wrong saved address is seen only when the return strobe redirects, so every return target is compared against the address recorded at entry. Priority and code errors show in the cause code field read back in the cycle after entry.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int XLEN      = 32;
    localparam int NUM_PEND  = 8;
    localparam int PEND_LSB  = 8;
    localparam int CODE_W    = 5;
    localparam int CODE_LSB  = 2;
    localparam logic [NUM_PEND-1:0] SW_PEND_MASK = 8'b0000_0110;
    localparam int NUM_HW    = NUM_PEND - $countones(SW_PEND_MASK);

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_EPC    = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        TAKE_NONE = 2'd0,
        TAKE_EXC  = 2'd1,
        TAKE_INT  = 2'd2,
        TAKE_RET  = 2'd3
    } take_e;

    typedef struct packed {
        logic                ie;
        logic                exl;
        logic [NUM_PEND-1:0] mask;
        logic [NUM_PEND-1:0] pend;
        logic [CODE_W-1:0]   code;
        logic [XLEN-1:0]     epc;
        logic                redirect;
        logic [XLEN-1:0]     redir_pc;
    } trap_state_t;

    // Index of the hardware line feeding pending position pos.
    function automatic int hw_line_of(logic [NUM_PEND-1:0] swm, int pos);
        int n;
        n = 0;
        for (int b = 0; b < pos; b++) begin
            if (!swm[b]) n++;
        end
        return n;
    endfunction

endpackage

// File: rtl/trap_pend.sv
module trap_pend #(
    parameter int                NP  = 8,
    parameter logic [NP-1:0]     SWM = '0
) (
    input  logic [NP-1:0] hw_req_i,
    input  logic [NP-1:0] pend_q_i,
    input  logic          wr_i,
    input  logic [NP-1:0] wr_bits_i,
    output logic [NP-1:0] pend_d_o
);

    for (genvar i = 0; i < NP; i++) begin : g_bit
        if (SWM[i]) begin : g_sw
            // software flag: fully owned by register writes
            assign pend_d_o[i] = (wr_i ? wr_bits_i[i] : pend_q_i[i]) | hw_req_i[i];
        end else begin : g_hw
            // hardware flag: set by line, write of 0 clears, request wins
            assign pend_d_o[i] = hw_req_i[i] | (pend_q_i[i] & ~(wr_i & ~wr_bits_i[i]));
        end
    end

endmodule

// File: rtl/trap_select.sv
module trap_select
    import trap_pkg::*;
#(
    parameter int NP = 8
) (
    input  logic          ie_i,
    input  logic          exl_i,
    input  logic [NP-1:0] pend_i,
    input  logic [NP-1:0] mask_i,
    input  logic          exc_valid_i,
    input  logic          eret_i,
    output take_e         take_o
);

    logic int_ready;

    always_comb begin
        int_ready = ie_i && !exl_i && (|(pend_i & mask_i));
        if (exc_valid_i) begin
            take_o = TAKE_EXC;
        end else if (eret_i) begin
            take_o = TAKE_RET;
        end else if (int_ready) begin
            take_o = TAKE_INT;
        end else begin
            take_o = TAKE_NONE;
        end
    end

endmodule

// File: rtl/trap_unit.sv
module trap_unit
    import trap_pkg::*;
#(
    parameter logic [31:0] HANDLER_ADDR = 32'h8000_0180
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   exc_valid_i,
    input  logic [CODE_W-1:0]      exc_code_i,
    input  logic [XLEN-1:0]        exc_pc_i,
    input  logic [XLEN-1:0]        irq_pc_i,
    input  logic [NUM_HW-1:0]      hw_irq_i,
    input  logic                   eret_i,
    input  logic                   wr_en_i,
    input  logic [1:0]             wr_sel_i,
    input  logic [XLEN-1:0]        wr_data_i,
    input  logic [1:0]             rd_sel_i,
    output logic [XLEN-1:0]        rd_data_o,
    output logic                   redirect_o,
    output logic [XLEN-1:0]        redirect_pc_o,
    output logic                   user_mode_o
);

    trap_state_t s_d, s_q;

    logic [NUM_PEND-1:0] hw_vec;
    logic [NUM_PEND-1:0] pend_d;
    logic                cause_wr;
    take_e               take;

    logic [XLEN-1:0]     epc_q;
    logic [CODE_W-1:0]   code_q;
    logic [NUM_PEND-1:0] pend_q;
    logic                exl_q;
    logic [XLEN-1:0]     status_rd;
    logic [XLEN-1:0]     cause_rd;

    assign epc_q  = s_q.epc;
    assign code_q = s_q.code;
    assign pend_q = s_q.pend;
    assign exl_q  = s_q.exl;

    // spread hardware lines over the non-software pending positions
    for (genvar i = 0; i < NUM_PEND; i++) begin : g_map
        if (SW_PEND_MASK[i]) begin : g_zero
            assign hw_vec[i] = 1'b0;
        end else begin : g_line
            assign hw_vec[i] = hw_irq_i[hw_line_of(SW_PEND_MASK, i)];
        end
    end

    assign cause_wr = wr_en_i && (wr_sel_i == SEL_CAUSE);

    trap_pend #(
        .NP  (NUM_PEND),
        .SWM (SW_PEND_MASK)
    ) i_pend (
        .hw_req_i  (hw_vec),
        .pend_q_i  (s_q.pend),
        .wr_i      (cause_wr),
        .wr_bits_i (wr_data_i[PEND_LSB +: NUM_PEND]),
        .pend_d_o  (pend_d)
    );

    trap_select #(
        .NP (NUM_PEND)
    ) i_sel (
        .ie_i        (s_q.ie),
        .exl_i       (s_q.exl),
        .pend_i      (s_q.pend),
        .mask_i      (s_q.mask),
        .exc_valid_i (exc_valid_i),
        .eret_i      (eret_i),
        .take_o      (take)
    );

    always_comb begin
        s_d          = s_q;
        s_d.redirect = 1'b0;
        s_d.pend     = pend_d;

        if (wr_en_i) begin
            case (wr_sel_i)
                SEL_STATUS: begin
                    s_d.ie   = wr_data_i[0];
                    s_d.exl  = wr_data_i[1];
                    s_d.mask = wr_data_i[PEND_LSB +: NUM_PEND];
                end
                SEL_EPC: begin
                    s_d.epc = wr_data_i;
                end
                default: begin
                end
            endcase
        end

        case (take)
            TAKE_EXC: begin
                s_d.exl      = 1'b1;
                s_d.code     = exc_code_i;
                if (!s_q.exl) begin
                    s_d.epc = exc_pc_i;
                end
                s_d.redirect = 1'b1;
                s_d.redir_pc = HANDLER_ADDR;
            end
            TAKE_INT: begin
                s_d.exl      = 1'b1;
                s_d.code     = '0;
                s_d.epc      = irq_pc_i;
                s_d.redirect = 1'b1;
                s_d.redir_pc = HANDLER_ADDR;
            end
            TAKE_RET: begin
                s_d.exl      = 1'b0;
                s_d.redirect = 1'b1;
                s_d.redir_pc = s_q.epc;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        status_rd = '0;
        status_rd[0] = s_q.ie;
        status_rd[1] = s_q.exl;
        status_rd[PEND_LSB +: NUM_PEND] = s_q.mask;

        cause_rd = '0;
        cause_rd[PEND_LSB +: NUM_PEND] = s_q.pend;
        cause_rd[CODE_LSB +: CODE_W]   = s_q.code;

        case (rd_sel_i)
            SEL_STATUS: rd_data_o = status_rd;
            SEL_CAUSE:  rd_data_o = cause_rd;
            SEL_EPC:    rd_data_o = s_q.epc;
            default:    rd_data_o = '0;
        endcase
    end

    assign redirect_o    = s_q.redirect;
    assign redirect_pc_o = s_q.redir_pc;
    assign user_mode_o   = ~s_q.exl;

endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk
    import trap_pkg::*;
#(
    parameter logic [31:0] HANDLER = 32'h8000_0180
) (
    input logic                clk,
    input logic                rst_n,
    input logic                exc_valid_i,
    input logic [CODE_W-1:0]   exc_code_i,
    input logic [XLEN-1:0]     exc_pc_i,
    input logic [NUM_HW-1:0]   hw_irq_i,
    input logic                eret_i,
    input logic                redirect_o,
    input logic [XLEN-1:0]     redirect_pc_o,
    input logic                user_mode_o,
    input logic [XLEN-1:0]     epc_q,
    input logic [CODE_W-1:0]   code_q,
    input logic [NUM_PEND-1:0] pend_q
);

    // R2
    entry_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_i |=> redirect_o && (redirect_pc_o == HANDLER) && !user_mode_o);

    // R3
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_i && user_mode_o |=> epc_q == $past(exc_pc_i));

    // R4
    code_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_i |=> code_q == $past(exc_code_i));

    // R5
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_irq_i[0] |=> pend_q[0]);

    // R9
    exl_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode_o && !exc_valid_i && !eret_i |=> !redirect_o);

    // R10
    return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eret_i && !exc_valid_i |=> redirect_o && user_mode_o && (redirect_pc_o == $past(epc_q)));

endmodule

bind trap_unit trap_unit_chk #(.HANDLER(HANDLER_ADDR)) i_trap_unit_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .exc_valid_i   (exc_valid_i),
    .exc_code_i    (exc_code_i),
    .exc_pc_i      (exc_pc_i),
    .hw_irq_i      (hw_irq_i),
    .eret_i        (eret_i),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .user_mode_o   (user_mode_o),
    .epc_q         (epc_q),
    .code_q        (code_q),
    .pend_q        (pend_q)
);

// File: tb/test_trap_unit.sv
module test_trap_unit;

    localparam logic [31:0] HANDLER = 32'h8000_0180;
    localparam logic [31:0] IRQ_PC  = 32'h0040_0020;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [31:0] exc_pc = '0;
    logic [31:0] irq_pc = IRQ_PC;
    logic [5:0]  hw_irq = '0;
    logic        eret = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        redirect;
    logic [31:0] redirect_pc;
    logic        user_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] exp_q[$];

    always #10 clk = ~clk;

    trap_unit i_trap_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .exc_valid_i   (exc_valid),
        .exc_code_i    (exc_code),
        .exc_pc_i      (exc_pc),
        .irq_pc_i      (irq_pc),
        .hw_irq_i      (hw_irq),
        .eret_i        (eret),
        .wr_en_i       (wr_en),
        .wr_sel_i      (wr_sel),
        .wr_data_i     (wr_data),
        .rd_sel_i      (rd_sel),
        .rd_data_o     (rd_data),
        .redirect_o    (redirect),
        .redirect_pc_o (redirect_pc),
        .user_mode_o   (user_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic fault(input logic [4:0] code, input logic [31:0] pc);
        exp_q.push_back(HANDLER);
        exc_valid = 1'b1; exc_code = code; exc_pc = pc;
        tick();
        exc_valid = 1'b0;
    endtask

    task automatic ret(input logic [31:0] target);
        exp_q.push_back(target);
        eret = 1'b1;
        tick();
        eret = 1'b0;
    endtask

    task automatic pulse_kbd();
        hw_irq[0] = 1'b1;
        tick();
        hw_irq[0] = 1'b0;
    endtask

    // scoreboard monitor: every redirect must match the next expected target
    always @(negedge clk) begin
        if (rst_n && redirect) begin
            if (exp_q.size() == 0) begin
                chk("R9 unexpected redirect", redirect_pc, 32'hxxxx_xxxx);
            end else begin
                chk("R2/R10 redirect target", redirect_pc, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(2'd0, v); chk("R1 status", v, 32'h0);
        rd(2'd1, v); chk("R1 cause", v, 32'h0);
        rd(2'd2, v); chk("R1 epc", v, 32'h0);
        chk("R1 redirect", {31'b0, redirect}, 32'h0);
        chk("R1 user mode", {31'b0, user_mode}, 32'h1);

        // R4 undefined instruction, R3 raw epc, R2 entry
        fault(5'd10, 32'h0040_0010);
        chk("R2 user mode low", {31'b0, user_mode}, 32'h0);
        rd(2'd1, v); chk("R4 cause undefined", v, 32'h28);
        rd(2'd2, v); chk("R3 epc fault", v, 32'h0040_0010);
        ret(32'h0040_0010);
        chk("R10 user mode back", {31'b0, user_mode}, 32'h1);

        // R5 pending while masked, R6 taken once unmasked
        wr(2'd0, 32'h0000_0001);
        pulse_kbd();
        chk("R5 no redirect masked", {31'b0, redirect}, 32'h0);
        rd(2'd1, v); chk("R5 cause pending bit8", v, 32'h0000_0128);
        tick();
        chk("R5 still no redirect", {31'b0, redirect}, 32'h0);
        exp_q.push_back(HANDLER);
        wr(2'd0, 32'h0000_0101);
        tick();
        rd(2'd1, v); chk("R4 interrupt code zero", v, 32'h0000_0100);
        rd(2'd2, v); chk("R3 epc interrupt", v, IRQ_PC);
        chk("R6 user mode low", {31'b0, user_mode}, 32'h0);

        // R9 blocked while exception level set
        pulse_kbd();
        tick();
        chk("R9 no redirect in handler", {31'b0, redirect}, 32'h0);
        wr(2'd1, 32'h0);
        rd(2'd1, v); chk("R7 hw flag cleared", v, 32'h0);
        ret(IRQ_PC);

        // R7 software flag drives an interrupt (mask bit 9)
        wr(2'd0, 32'h0000_0201);
        exp_q.push_back(HANDLER);
        wr(2'd1, 32'h0000_0200);
        tick();
        rd(2'd1, v); chk("R7 sw flag set", v, 32'h0000_0200);
        wr(2'd1, 32'h0);
        rd(2'd1, v); chk("R7 sw flag cleared", v, 32'h0);
        ret(IRQ_PC);

        // R7 write of 1 to hw flag ignored, other sw flag writable
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0000_0100);
        rd(2'd1, v); chk("R7 hw flag not writable", v, 32'h0);
        wr(2'd1, 32'h0000_0400);
        rd(2'd1, v); chk("R7 sw bit10 set", v, 32'h0000_0400);
        wr(2'd1, 32'hFFFF_00FF);
        rd(2'd1, v); chk("R11 code and bit31 read zero", v, 32'h0);

        // R8 fault beats a takeable interrupt in the same cycle
        wr(2'd0, 32'h0000_0100);
        pulse_kbd();
        wr(2'd0, 32'h0000_0101);
        fault(5'd10, 32'h0040_0044);
        rd(2'd1, v); chk("R8 fault code wins", v, 32'h0000_0128);
        rd(2'd2, v); chk("R8 fault epc wins", v, 32'h0040_0044);
        wr(2'd1, 32'h0);
        ret(32'h0040_0044);
        tick();
        chk("R8 no late interrupt", {31'b0, redirect}, 32'h0);

        // R9 nested fault keeps epc, R4 overflow and address codes
        wr(2'd0, 32'h0);
        fault(5'd12, 32'h0040_0008);
        rd(2'd1, v); chk("R4 cause overflow", v, 32'h30);
        fault(5'd4, 32'h0040_0100);
        rd(2'd1, v); chk("R4 cause address", v, 32'h10);
        rd(2'd2, v); chk("R9 epc kept", v, 32'h0040_0008);
        ret(32'h0040_0008);

        // R10 software-written return address, R11 select 3
        wr(2'd2, 32'h0040_0200);
        ret(32'h0040_0200);
        rd(2'd3, v); chk("R11 select3 zero", v, 32'h0);
        rd(2'd0, v); chk("R11 status layout", v, 32'h0);

        repeat (3) tick();
        chk("R2 all redirects seen", exp_q.size(), 32'd0);
        finish_run();
    end

endmodule